// File: doc/BRIEF.md
# Virtual Address Segment Front End

This block sits in front of a translation lookaside buffer and sorts every virtual address by its three top bits. Two kernel windows are not mapped: the cached window (top bits `100`) and the uncached window (top bits `101`). For these, the block forms the physical address itself by clearing the three window bits. Every other address goes on to the translation buffer unchanged. Before any of this, the block checks alignment and privilege. A failed check gives an address-error fault, and the faulting virtual address is captured with it.

Each accepted request gives one registered result one clock later. The result is a direct physical address, a translation request, or a fault. The shared address output carries the physical address, the address to translate, or the faulting address, depending on which of these it is. An uncacheable attribute comes with every non-fault result. It is set when address bits 31 and 29 are both one.

Top module: `vaddr_seg_front`

## Requirements
- R1: After reset, and in any cycle that follows a cycle without `reqValid`, `outDirect`, `outMapped`, `outFault`, `outFaultStore`, `outFaultAlign` and `outUncached` are all 0.
- R2: A request whose top three bits are `100` (cached kernel window), made in kernel mode and aligned, raises `outDirect` one cycle later. `outAddr` then equals the virtual address with bits 31..29 cleared.
- R3: A request whose top three bits are `101` (uncached kernel window) and that is aligned raises `outDirect` one cycle later. `outAddr` then equals the virtual address with bits 31..29 cleared.
- R4: A request into the cached kernel window made with `kernelMode`=0 raises `outFault` with `outFaultAlign`=0. `outAddr` then holds the faulting virtual address.
- R5: The uncached kernel window is reachable with `kernelMode`=0 and faults on no privilege check.
- R6: A request is misaligned when `reqSize`=2 and address bit 0 is 1, or when `reqSize`=4 and address bits 1..0 are not 00. Such a request raises `outFault` with `outFaultAlign`=1 and `outAddr` equal to the virtual address. `reqSize`=1 is never misaligned.
- R7: `reqKind` encodes fetch as 0, load as 1 and store as 2. A fault raised by a store request sets `outFaultStore`=1. A fault raised by any other kind sets `outFaultStore`=0.
- R8: When a request is both misaligned and a non-kernel access to the cached window, the alignment fault wins, so `outFaultAlign`=1.
- R9: With `outDirect` or `outMapped`, `outUncached`=1 exactly when virtual address bits 31 and 29 are both 1. With `outFault`, `outUncached`=0.
- R10: Aligned requests outside both kernel windows raise `outMapped`, with `outAddr` equal to the unchanged virtual address.
- R11: At most one of `outDirect`, `outMapped` and `outFault` is 1 in any cycle. Exactly one is 1 in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqVaddr | input | 32 | Virtual address |
| reqSize | input | 3 | Access size in bytes (1, 2 or 4) |
| reqKind | input | 2 | 0 fetch, 1 load, 2 store |
| kernelMode | input | 1 | Requester runs with kernel privilege |
| outDirect | output | 1 | Unmapped result, `outAddr` is physical |
| outMapped | output | 1 | Forward to translation, `outAddr` is virtual |
| outFault | output | 1 | Address-error fault, `outAddr` is the bad address |
| outFaultStore | output | 1 | Fault raised by a store |
| outFaultAlign | output | 1 | Fault cause is misalignment |
| outUncached | output | 1 | Result must bypass caches |
| outAddr | output | 32 | Result address |

## Verification
The bench goes after the edges of each window: 0x9FFFFFFC, 0xBFFFFFFE, 0x7FFFFFF0 and 0xC0000000. A decoder that compared the wrong number of top bits would classify one of these wrongly. It sends requests that fail both checks at once, so a design with the fault priority reversed reports a privilege fault. A size-1 access on an odd address would fault in a design that tested alignment against a fixed mask. Addresses with only bit 29 set, or with bits 31 and 29 both set, catch an uncacheable rule that tests only one bit. Back-to-back requests and idle gaps expose stale result flags.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } vsegKind_e;

  // Per-request decision strobes from control to datapath.
  typedef struct packed {
    logic direct;
    logic mapped;
    logic fault;
    logic faultStore;
    logic faultAlign;
    logic uncached;
  } vsegStrobe_t;
endpackage

// File: rtl/vseg_ctrl.sv
module vseg_ctrl
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int SEG_W = 3,
  parameter logic [SEG_W-1:0] WIN_CACHED = 3'b100,
  parameter logic [SEG_W-1:0] WIN_UNCACHED = 3'b101,
  parameter logic [ADDR_W-1:0] UNC_MASK = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [1:0]        reqKind,
  input  logic              kernelMode,
  output vsegStrobe_t       stb,
  output vsegStrobe_t       flags
);
  localparam int LOW_W = SIZE_W - 1;

  logic [SEG_W-1:0]  seg;
  logic [SIZE_W-1:0] misMask;
  logic              misaligned;
  logic              uncAttr;
  logic              isStore;

  assign seg     = reqVaddr[ADDR_W-1 -: SEG_W];
  assign uncAttr = (reqVaddr & UNC_MASK) == UNC_MASK;
  assign isStore = reqKind == KIND_STORE;

  // Only power-of-two sizes carry an alignment requirement.
  always_comb begin
    misMask = '0;
    if (reqSize != '0 && (reqSize & (reqSize - 1'b1)) == '0)
      misMask = reqSize - 1'b1;
  end
  assign misaligned = |(reqVaddr[LOW_W-1:0] & misMask[LOW_W-1:0]);

  always_comb begin
    stb = '0;
    if (reqValid) begin
      if (misaligned) begin
        stb.fault      = 1'b1;
        stb.faultAlign = 1'b1;
        stb.faultStore = isStore;
      end else if (seg == WIN_CACHED && !kernelMode) begin
        stb.fault      = 1'b1;
        stb.faultStore = isStore;
      end else if (seg == WIN_CACHED || seg == WIN_UNCACHED) begin
        stb.direct   = 1'b1;
        stb.uncached = uncAttr;
      end else begin
        stb.mapped   = 1'b1;
        stb.uncached = uncAttr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= stb;
  end
endmodule

// File: rtl/vseg_dpath.sv
module vseg_dpath
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  vsegStrobe_t       stb,
  input  logic [ADDR_W-1:0] reqVaddr,
  output logic [ADDR_W-1:0] outAddr
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] stripped;
  assign stripped = {{SEG_W{1'b0}}, reqVaddr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN)                      outAddr <= '0;
    else if (stb.direct)            outAddr <= stripped;
    else if (stb.mapped | stb.fault) outAddr <= reqVaddr;
  end
endmodule

// File: rtl/vaddr_seg_front.sv
module vaddr_seg_front
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int SEG_W = 3,
  parameter logic [SEG_W-1:0] WIN_CACHED = 3'b100,
  parameter logic [SEG_W-1:0] WIN_UNCACHED = 3'b101,
  parameter logic [ADDR_W-1:0] UNC_MASK = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [1:0]        reqKind,
  input  logic              kernelMode,
  output logic              outDirect,
  output logic              outMapped,
  output logic              outFault,
  output logic              outFaultStore,
  output logic              outFaultAlign,
  output logic              outUncached,
  output logic [ADDR_W-1:0] outAddr
);
  vsegStrobe_t stb;
  vsegStrobe_t flags;

  vseg_ctrl #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEG_W(SEG_W),
    .WIN_CACHED(WIN_CACHED), .WIN_UNCACHED(WIN_UNCACHED), .UNC_MASK(UNC_MASK)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqSize(reqSize), .reqKind(reqKind), .kernelMode(kernelMode),
    .stb(stb), .flags(flags)
  );

  vseg_dpath #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVaddr(reqVaddr), .outAddr(outAddr)
  );

  assign outDirect     = flags.direct;
  assign outMapped     = flags.mapped;
  assign outFault      = flags.fault;
  assign outFaultStore = flags.faultStore;
  assign outFaultAlign = flags.faultAlign;
  assign outUncached   = flags.uncached;
endmodule

// File: rtl/vseg_front_chk.sv
module vseg_front_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic [SIZE_W-1:0] reqSize,
  input logic              kernelMode,
  input logic              outDirect,
  input logic              outMapped,
  input logic              outFault,
  input logic              outFaultAlign,
  input logic              outUncached,
  input logic [ADDR_W-1:0] outAddr
);
  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outDirect, outMapped, outFault}));

  // R11
  req_answered_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (outDirect | outMapped | outFault));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(outDirect | outMapped | outFault | outUncached));

  // R2
  direct_stripped_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDirect |-> outAddr[ADDR_W-1 -: 3] == 3'b000);

  // R4
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVaddr[ADDR_W-1 -: 3] == 3'b100 && !kernelMode) |=> outFault);

  // R6
  half_misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 3'd2 && reqVaddr[0]) |=> (outFault && outFaultAlign));

  // R9
  fault_cacheless_chk: assert property (@(posedge clk) disable iff (!rstN)
    outFault |-> !outUncached);
endmodule

bind vaddr_seg_front vseg_front_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
  .reqSize(reqSize), .kernelMode(kernelMode), .outDirect(outDirect),
  .outMapped(outMapped), .outFault(outFault), .outFaultAlign(outFaultAlign),
  .outUncached(outUncached), .outAddr(outAddr)
);

// File: tb/test_vaddr_seg_front.sv
`timescale 1ns/1ps
module test_vaddr_seg_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [1:0]  reqKind = 2'd0;
  logic        kernelMode = 1'b0;
  logic        outDirect, outMapped, outFault, outFaultStore, outFaultAlign, outUncached;
  logic [31:0] outAddr;

  int total = 0;
  int bad = 0;

  // cls: 1 direct, 2 mapped, 3 fault
  typedef struct {
    int          cls;
    logic [31:0] addr;
    logic        unc;
    logic        store;
    logic        align;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #4 clk = ~clk;

  vaddr_seg_front i_vaddr_seg_front (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqSize(reqSize), .reqKind(reqKind), .kernelMode(kernelMode),
    .outDirect(outDirect), .outMapped(outMapped), .outFault(outFault),
    .outFaultStore(outFaultStore), .outFaultAlign(outFaultAlign),
    .outUncached(outUncached), .outAddr(outAddr)
  );

  task automatic send(input logic [31:0] va, input logic [2:0] sz, input logic [1:0] kd,
                      input logic kern, input int cls, input logic [31:0] ea,
                      input logic eu, input logic es, input logic eal, input string tag);
    expItem_t e;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqSize = sz; reqKind = kd; kernelMode = kern;
    e.cls = cls; e.addr = ea; e.unc = eu; e.store = es; e.align = eal; e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // Monitor: note the request at the edge, compare a little later.
  initial begin
    forever begin
      logic hadReq;
      @(posedge clk);
      hadReq = reqValid && rstN;
      #2;
      if (rstN && hadReq) begin
        expItem_t e;
        int gotCls;
        e = sbQ.pop_front();
        gotCls = outDirect ? 1 : outMapped ? 2 : outFault ? 3 : 0;
        total++;
        if (gotCls != e.cls || $countones({outDirect, outMapped, outFault}) != 1) begin
          bad++;
          $display("FAIL %s class got=%0d expected=%0d", e.tag, gotCls, e.cls);
        end else if (outAddr !== e.addr) begin
          bad++;
          $display("FAIL %s addr got=%h expected=%h", e.tag, outAddr, e.addr);
        end else if (outUncached !== e.unc) begin
          bad++;
          $display("FAIL %s uncached got=%b expected=%b", e.tag, outUncached, e.unc);
        end else if (e.cls == 3 && (outFaultStore !== e.store || outFaultAlign !== e.align)) begin
          bad++;
          $display("FAIL %s store/align got=%b%b expected=%b%b", e.tag,
                   outFaultStore, outFaultAlign, e.store, e.align);
        end
      end else if (rstN) begin
        total++;
        if ({outDirect, outMapped, outFault, outFaultStore, outFaultAlign, outUncached} != 6'b0) begin
          bad++;
          $display("FAIL R1 idle flags got=%b expected=000000",
                   {outDirect, outMapped, outFault, outFaultStore, outFaultAlign, outUncached});
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // R2 cached window, kernel
    send(32'h8000_1234, 3'd4, 2'd1, 1'b1, 1, 32'h0000_1234, 1'b0, 1'b0, 1'b0, "R2");
    send(32'h9FFF_FFFC, 3'd4, 2'd0, 1'b1, 1, 32'h1FFF_FFFC, 1'b0, 1'b0, 1'b0, "R2");
    // R3 R5 R9 uncached window, user mode allowed
    send(32'hA000_0010, 3'd4, 2'd1, 1'b0, 1, 32'h0000_0010, 1'b1, 1'b0, 1'b0, "R5");
    send(32'hBFFF_FFFE, 3'd2, 2'd2, 1'b1, 1, 32'h1FFF_FFFE, 1'b1, 1'b0, 1'b0, "R3");
    idle(1);
    // R4 R7 privilege faults
    send(32'h8000_0000, 3'd4, 2'd0, 1'b0, 3, 32'h8000_0000, 1'b0, 1'b0, 1'b0, "R4");
    send(32'h8000_0101, 3'd1, 2'd2, 1'b0, 3, 32'h8000_0101, 1'b0, 1'b1, 1'b0, "R7");
    // R6 alignment
    send(32'h0040_0001, 3'd2, 2'd1, 1'b1, 3, 32'h0040_0001, 1'b0, 1'b0, 1'b1, "R6");
    send(32'h0040_0002, 3'd4, 2'd2, 1'b1, 3, 32'h0040_0002, 1'b0, 1'b1, 1'b1, "R6");
    send(32'h0040_0003, 3'd1, 2'd1, 1'b1, 2, 32'h0040_0003, 1'b0, 1'b0, 1'b0, "R6");
    // R8 both checks fail, alignment wins
    send(32'h8000_0002, 3'd4, 2'd1, 1'b0, 3, 32'h8000_0002, 1'b0, 1'b0, 1'b1, "R8");
    idle(2);
    // R10 R9 mapped
    send(32'h7FFF_FFF0, 3'd4, 2'd0, 1'b0, 2, 32'h7FFF_FFF0, 1'b0, 1'b0, 1'b0, "R10");
    send(32'hE000_0000, 3'd4, 2'd1, 1'b1, 2, 32'hE000_0000, 1'b1, 1'b0, 1'b0, "R9");
    send(32'hC000_0000, 3'd4, 2'd1, 1'b1, 2, 32'hC000_0000, 1'b0, 1'b0, 1'b0, "R9");
    send(32'h2000_0000, 3'd2, 2'd2, 1'b0, 2, 32'h2000_0000, 1'b0, 1'b0, 1'b0, "R10");
    // R11 kernel mapped access after faults
    send(32'h0000_0008, 3'd4, 2'd2, 1'b1, 2, 32'h0000_0008, 1'b0, 1'b0, 1'b0, "R11");
    idle(3);
    if (sbQ.size() != 0) begin
      bad++;
      $display("FAIL R11 unanswered got=%0d expected=0", sbQ.size());
    end
    total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog got=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule